// File: doc/BRIEF.md
# VEX Prefix Byte Decoder

This block sits at the front of an x86 instruction decoder. It takes instruction bytes one at a time over a valid/ready handshake and works out whether the instruction begins with a two-byte or three-byte vector-extension (VEX) prefix. If it does, the block unpacks the prefix. It produces the un-inverted register-extension bits, the operand-width bit, the extra source register number, the vector-length bit and the implied legacy prefix. It also resolves the opcode map and reports the opcode as a 9-bit value tagged with that map. Any other byte is passed on as a plain one-byte-map opcode.

The lead bytes 0xC4 and 0xC5 are ambiguous, and the block settles this. In 16-bit code and in virtual-8086 mode they are always the segment-load opcodes. In 32-bit code the block looks at the following byte without accepting it. It commits to a prefix only when that byte has its top two bits set. If not, it leaves the byte on the bus for the operand stage. Legacy prefixes already seen are given as flags, and any of them makes a VEX form illegal. Each instruction ends with a one-cycle done pulse, and the result fields stay on the outputs until the next done pulse.

Top module: `vex_decoder`

## Requirements
- R1: In the idle state, any accepted byte other than a VEX lead byte in a VEX-capable mode ends the instruction. The result is opcode {1'b0, byte} with the VEX flag 0, and exactly one byte is consumed.
- R2: `cpu_mode` is coded 0 = 16-bit, 1 = 32-bit and 2 = 64-bit. VEX is decoded only in modes 1 and 2 while `v86_mode` is 0. In every other case, lead bytes 0xC4 and 0xC5 finish at once as opcodes 0x0C4 and 0x0C5 after consuming one byte.
- R3: In mode 1, a byte after a lead byte whose bits [7:6] are not 2'b11 is not accepted (`byte_ready` stays 0). The instruction finishes as opcode 0x0C4 or 0x0C5, and one byte in total is consumed. In mode 2 the byte is always taken as the first payload byte.
- R4: If any of `seen_lock`, `seen_opsize`, `seen_rep`, `seen_repne` or `seen_rex` is 1 when a VEX prefix is committed, the instruction ends illegal after two bytes are consumed.
- R5: First payload byte: `ext_r` is the inverse of bit 7. In the three-byte form, `ext_x` is the inverse of bit 6 and `ext_b` is the inverse of bit 5. In the two-byte form, `ext_x` and `ext_b` are 0.
- R6: In the three-byte form (lead 0xC4), bits [4:0] of the first payload byte select the map. With 1, the byte after the second payload byte is read and the opcode is 0x100 | byte. With 2, the opcode is 0x138, and with 3 it is 0x13A, and no opcode byte is read for either. Any other value is illegal after two bytes.
- R7: In the three-byte form, `op_wide` is bit 7 of the second payload byte. In the two-byte form it is 0.
- R8: In the two-byte form (lead 0xC5), the single payload byte is also the last payload byte. The next byte is the opcode, tagged 0x100 | byte, for three bytes consumed.
- R9: From the last payload byte, `src_reg` is the inverse of bits [6:3] and `vec_long` is bit 2. Bits [1:0] set `imp_opsize` for value 1, `imp_rep` for value 2 and `imp_repne` for value 3, and set none of them for value 0.
- R10: When no VEX prefix is decoded, and on any illegal result, `src_reg`, `vec_long`, the extension bits, `op_wide` and the implied prefixes are 0. An illegal result also has opcode 0 and `dec_vex` 0.
- R11: `dec_done` is high for one cycle, the cycle after the last byte is consumed or the cycle after the look-ahead refusal. All result outputs hold their values while `dec_done` is low.
- R12: A synchronous active-low reset returns the block to idle, clears `dec_done`, and clears every result output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | An instruction byte is offered |
| byte_data | input | 8 | Offered instruction byte |
| byte_ready | output | 1 | The offered byte is accepted at this edge |
| cpu_mode | input | 2 | Code size: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit |
| v86_mode | input | 1 | Virtual-8086 mode active |
| seen_lock | input | 1 | A lock prefix precedes this instruction |
| seen_opsize | input | 1 | A 0x66 prefix precedes this instruction |
| seen_rep | input | 1 | A 0xF3 prefix precedes this instruction |
| seen_repne | input | 1 | A 0xF2 prefix precedes this instruction |
| seen_rex | input | 1 | A REX prefix precedes this instruction |
| dec_done | output | 1 | One-cycle instruction-finished pulse |
| dec_opcode | output | 9 | Map-tagged opcode |
| dec_vex | output | 1 | A VEX prefix was decoded |
| ext_r | output | 1 | Register extension of the ModRM reg field |
| ext_x | output | 1 | Register extension of the index |
| ext_b | output | 1 | Register extension of the base or rm field |
| op_wide | output | 1 | Operand-width bit |
| src_reg | output | 4 | Extra source register number |
| vec_long | output | 1 | Vector-length bit |
| imp_opsize | output | 1 | Implied 0x66 prefix |
| imp_rep | output | 1 | Implied 0xF3 prefix |
| imp_repne | output | 1 | Implied 0xF2 prefix |
| dec_illegal | output | 1 | The instruction encoding is illegal |

## Verification
Every byte value is offered as the lone byte in 32-bit mode. This separates plain opcodes from lead bytes. All 256 follow-on bytes are tried after 0xC5 in 32-bit mode, which separates the refused look-ahead from committed two-byte forms and checks every register and pp field. After 0xC4 in 64-bit mode, all 256 first payload bytes are swept to cover all map codes, legal and reserved, together with the inverted extension bits. All 256 second payload bytes are swept to cover W, vvvv, L and pp. A grid of mode, virtual-8086 mode and lead byte, a sweep over each stale-prefix flag, and a reset taken mid-instruction complete the set.

// File: rtl/vex_pkg.sv
// Package: shared constants and types for the VEX prefix decoder.
// Assumes one instruction byte per handshake and 9-bit map-tagged opcodes.
package vex_pkg;

    localparam int BYTE_W = 8;
    localparam int OPC_W  = BYTE_W + 1;
    localparam int MAP_W  = 5;
    localparam int REG_W  = 4;
    localparam int MODE_W = 2;

    localparam logic [BYTE_W-1:0] LEAD_VEX2 = 8'hC5;
    localparam logic [BYTE_W-1:0] LEAD_VEX3 = 8'hC4;

    localparam logic [MODE_W-1:0] MODE_16 = 2'd0;
    localparam logic [MODE_W-1:0] MODE_32 = 2'd1;
    localparam logic [MODE_W-1:0] MODE_64 = 2'd2;

    localparam logic [MAP_W-1:0] MAP_0F   = 5'd1;
    localparam logic [MAP_W-1:0] MAP_0F38 = 5'd2;
    localparam logic [MAP_W-1:0] MAP_0F3A = 5'd3;

    localparam logic [OPC_W-1:0] OPC_0F38 = 9'h138;
    localparam logic [OPC_W-1:0] OPC_0F3A = 9'h13A;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEEK,
        ST_PAY2,
        ST_OPC
    } dec_state_t;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic             vex;
        logic             r;
        logic             x;
        logic             b;
        logic             w;
        logic [REG_W-1:0] vvvv;
        logic             vl;
        logic             p66;
        logic             pf3;
        logic             pf2;
        logic             illegal;
    } dec_result_t;

endpackage

// File: rtl/vex_map_select.sv
// Module: decodes the opcode-map selector of the three-byte form.
// Assumes the selector is the low five bits of the first payload byte.
module vex_map_select
    import vex_pkg::*;
(
    input  logic [MAP_W-1:0] map_code,
    output logic             map_ok,
    output logic             map_needs_opc,
    output logic [OPC_W-1:0] implied_opc
);

    // Classify the selector and give the implied opcode for the fixed maps.
    always_comb begin
        map_ok        = 1'b0;
        map_needs_opc = 1'b0;
        implied_opc   = '0;
        unique case (map_code)
            MAP_0F: begin
                map_ok        = 1'b1;
                map_needs_opc = 1'b1;
            end
            MAP_0F38: begin
                map_ok      = 1'b1;
                implied_opc = OPC_0F38;
            end
            MAP_0F3A: begin
                map_ok      = 1'b1;
                implied_opc = OPC_0F3A;
            end
            default: begin
                map_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vex_last_fields.sv
// Module: unpacks the register, length and implied-prefix fields of the
// last payload byte. Assumes bit 7 (the width bit) is handled elsewhere.
module vex_last_fields
    import vex_pkg::*;
(
    input  logic [BYTE_W-2:0] last_byte,
    output logic [REG_W-1:0]  vvvv,
    output logic              vl,
    output logic              p66,
    output logic              pf3,
    output logic              pf2
);

    // Un-invert the register number and expand pp into prefix flags.
    always_comb begin
        vvvv = ~last_byte[6:3];
        vl   = last_byte[2];
        p66  = (last_byte[1:0] == 2'd1);
        pf3  = (last_byte[1:0] == 2'd2);
        pf2  = (last_byte[1:0] == 2'd3);
    end

endmodule

// File: rtl/vex_fsm.sv
// Module: byte-stream state machine. It tells VEX lead bytes from the
// segment-load opcodes, steps through the payload and builds the result.
// Assumes the legacy prefix flags are stable for the whole instruction.
module vex_fsm
    import vex_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_data,
    output logic               in_ready,
    input  logic [MODE_W-1:0]  mode,
    input  logic               v86,
    input  logic               pfx_bad,
    output logic [MAP_W-1:0]   map_code,
    input  logic               map_ok,
    input  logic               map_needs_opc,
    input  logic [OPC_W-1:0]   implied_opc,
    output logic [BYTE_W-2:0]  last_src,
    input  logic [REG_W-1:0]   vvvv,
    input  logic               vl,
    input  logic               p66,
    input  logic               pf3,
    input  logic               pf2,
    output logic               finish,
    output dec_result_t        result
);

    dec_state_t        state, state_n;
    logic [BYTE_W-1:0] lead_q;
    logic [BYTE_W-1:0] p1_q;
    logic [BYTE_W-2:0] last_q;
    logic              w_q;
    logic              vex_mode;
    logic              is_lead;
    logic              take_vex;
    logic              lead3;
    logic              accept;
    dec_result_t       vex_res;
    dec_result_t       bad_res;

    // Decode the mode gate, lead byte and look-ahead decision.
    always_comb begin
        vex_mode = ((mode == MODE_32) || (mode == MODE_64)) && !v86;
        is_lead  = (in_data == LEAD_VEX2) || (in_data == LEAD_VEX3);
        take_vex = (mode == MODE_64) || (in_data[7:6] == 2'b11);
        lead3    = (lead_q == LEAD_VEX3);
        map_code = (state == ST_PEEK) ? in_data[MAP_W-1:0] : p1_q[MAP_W-1:0];
        last_src = (state == ST_PAY2) ? in_data[BYTE_W-2:0] : last_q;
    end

    // Assemble the result of a decoded VEX form and of an illegal one.
    always_comb begin
        vex_res         = '0;
        vex_res.vex     = 1'b1;
        vex_res.r       = ~p1_q[7];
        vex_res.x       = lead3 ? ~p1_q[6] : 1'b0;
        vex_res.b       = lead3 ? ~p1_q[5] : 1'b0;
        vex_res.w       = lead3 ? ((state == ST_PAY2) ? in_data[7] : w_q) : 1'b0;
        vex_res.vvvv    = vvvv;
        vex_res.vl      = vl;
        vex_res.p66     = p66;
        vex_res.pf3     = pf3;
        vex_res.pf2     = pf2;
        bad_res         = '0;
        bad_res.illegal = 1'b1;
    end

    // Next state, handshake and finishing result for each state.
    always_comb begin
        state_n  = state;
        in_ready = 1'b0;
        finish   = 1'b0;
        result   = '0;
        unique case (state)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (is_lead && vex_mode) begin
                        state_n = ST_PEEK;
                    end else begin
                        finish     = 1'b1;
                        result.opc = {1'b0, in_data};
                    end
                end
            end
            ST_PEEK: begin
                in_ready = take_vex;
                if (in_valid) begin
                    state_n = ST_IDLE;
                    finish  = 1'b1;
                    if (!take_vex) begin
                        result.opc = {1'b0, lead_q};
                    end else if (pfx_bad) begin
                        result = bad_res;
                    end else if (!lead3) begin
                        finish  = 1'b0;
                        state_n = ST_OPC;
                    end else if (!map_ok) begin
                        result = bad_res;
                    end else begin
                        finish  = 1'b0;
                        state_n = ST_PAY2;
                    end
                end
            end
            ST_PAY2: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (map_needs_opc) begin
                        state_n = ST_OPC;
                    end else begin
                        state_n    = ST_IDLE;
                        finish     = 1'b1;
                        result     = vex_res;
                        result.opc = implied_opc;
                    end
                end
            end
            ST_OPC: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    state_n    = ST_IDLE;
                    finish     = 1'b1;
                    result     = vex_res;
                    result.opc = {1'b1, in_data};
                end
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    assign accept = in_valid && in_ready;

    // State register and capture of the lead and payload bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            lead_q <= '0;
            p1_q   <= '0;
            last_q <= '0;
            w_q    <= 1'b0;
        end else begin
            state <= state_n;
            if (accept) begin
                unique case (state)
                    ST_IDLE: lead_q <= in_data;
                    ST_PEEK: begin
                        p1_q   <= in_data;
                        last_q <= in_data[BYTE_W-2:0];
                    end
                    ST_PAY2: begin
                        w_q    <= in_data[7];
                        last_q <= in_data[BYTE_W-2:0];
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // R3: a refused look-ahead byte ends the instruction and returns to idle.
    p_peek_refusal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEEK && in_valid && !in_ready) |=> (state == ST_IDLE));

    // R2: outside the VEX-capable modes the machine never leaves idle.
    p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !vex_mode) |=> (state == ST_IDLE));

    // R12: reset puts the machine back in idle.
    p_reset_idle_r12: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE));

endmodule

// File: rtl/vex_decoder.sv
// Module: top of the VEX prefix decoder. It joins the state machine and the
// field decoders and registers the result behind a one-cycle done pulse.
// Assumes a synchronous active-low reset and a single clock.
module vex_decoder
    import vex_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_ready,
    input  logic [MODE_W-1:0] cpu_mode,
    input  logic              v86_mode,
    input  logic              seen_lock,
    input  logic              seen_opsize,
    input  logic              seen_rep,
    input  logic              seen_repne,
    input  logic              seen_rex,
    output logic              dec_done,
    output logic [OPC_W-1:0]  dec_opcode,
    output logic              dec_vex,
    output logic              ext_r,
    output logic              ext_x,
    output logic              ext_b,
    output logic              op_wide,
    output logic [REG_W-1:0]  src_reg,
    output logic              vec_long,
    output logic              imp_opsize,
    output logic              imp_rep,
    output logic              imp_repne,
    output logic              dec_illegal
);

    logic [MAP_W-1:0]  map_code;
    logic              map_ok;
    logic              map_needs_opc;
    logic [OPC_W-1:0]  implied_opc;
    logic [BYTE_W-2:0] last_src;
    logic [REG_W-1:0]  lf_vvvv;
    logic              lf_vl;
    logic              lf_p66;
    logic              lf_pf3;
    logic              lf_pf2;
    logic              finish;
    logic              pfx_bad;
    dec_result_t       result;
    dec_result_t       res_q;
    logic              done_q;

    assign pfx_bad = seen_lock | seen_opsize | seen_rep | seen_repne | seen_rex;

    vex_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (byte_valid),
        .in_data       (byte_data),
        .in_ready      (byte_ready),
        .mode          (cpu_mode),
        .v86           (v86_mode),
        .pfx_bad       (pfx_bad),
        .map_code      (map_code),
        .map_ok        (map_ok),
        .map_needs_opc (map_needs_opc),
        .implied_opc   (implied_opc),
        .last_src      (last_src),
        .vvvv          (lf_vvvv),
        .vl            (lf_vl),
        .p66           (lf_p66),
        .pf3           (lf_pf3),
        .pf2           (lf_pf2),
        .finish        (finish),
        .result        (result)
    );

    vex_map_select u_map (
        .map_code      (map_code),
        .map_ok        (map_ok),
        .map_needs_opc (map_needs_opc),
        .implied_opc   (implied_opc)
    );

    vex_last_fields u_last (
        .last_byte (last_src),
        .vvvv      (lf_vvvv),
        .vl        (lf_vl),
        .p66       (lf_p66),
        .pf3       (lf_pf3),
        .pf2       (lf_pf2)
    );

    // Output register: capture the result on finish and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= finish;
            if (finish) begin
                res_q <= result;
            end
        end
    end

    assign dec_done    = done_q;
    assign dec_opcode  = res_q.opc;
    assign dec_vex     = res_q.vex;
    assign ext_r       = res_q.r;
    assign ext_x       = res_q.x;
    assign ext_b       = res_q.b;
    assign op_wide     = res_q.w;
    assign src_reg     = res_q.vvvv;
    assign vec_long    = res_q.vl;
    assign imp_opsize  = res_q.p66;
    assign imp_rep     = res_q.pf3;
    assign imp_repne   = res_q.pf2;
    assign dec_illegal = res_q.illegal;

    // R11: results hold while no instruction finishes.
    p_hold_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_done |-> $stable(res_q));

    // R8: a decoded VEX form always carries a map-tagged opcode.
    p_map_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && dec_vex) |-> dec_opcode[OPC_W-1]);

    // R10: without VEX the vector fields stay at their defaults.
    p_novex_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && !dec_vex) |-> (src_reg == '0 && !vec_long && !op_wide && !ext_r));

    // R10: an illegal result carries no VEX flag and no opcode.
    p_illegal_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_illegal |-> (!dec_vex && dec_opcode == '0));

    // R9: at most one implied prefix is reported.
    p_one_prefix_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({imp_opsize, imp_rep, imp_repne}));

    // R12: after reset no instruction is reported as finished.
    p_reset_done_r12: assert property (@(posedge clk)
        !rst_n |=> (!dec_done && !dec_illegal));

endmodule

// File: tb/vex_decoder_bench.sv
module vex_decoder_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_ready;
    logic [1:0] cpu_mode = 2'd1;
    logic       v86_mode = 1'b0;
    logic       seen_lock = 1'b0;
    logic       seen_opsize = 1'b0;
    logic       seen_rep = 1'b0;
    logic       seen_repne = 1'b0;
    logic       seen_rex = 1'b0;
    logic       dec_done;
    logic [8:0] dec_opcode;
    logic       dec_vex;
    logic       ext_r, ext_x, ext_b, op_wide;
    logic [3:0] src_reg;
    logic       vec_long, imp_opsize, imp_rep, imp_repne, dec_illegal;

    int checks = 0;
    int errors = 0;

    // expected-result bookkeeping
    logic [22:0] e_vec;
    int          e_n;
    string       e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    vex_decoder u_vex_decoder (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .cpu_mode(cpu_mode), .v86_mode(v86_mode),
        .seen_lock(seen_lock), .seen_opsize(seen_opsize), .seen_rep(seen_rep),
        .seen_repne(seen_repne), .seen_rex(seen_rex), .dec_done(dec_done),
        .dec_opcode(dec_opcode), .dec_vex(dec_vex), .ext_r(ext_r), .ext_x(ext_x),
        .ext_b(ext_b), .op_wide(op_wide), .src_reg(src_reg), .vec_long(vec_long),
        .imp_opsize(imp_opsize), .imp_rep(imp_rep), .imp_repne(imp_repne),
        .dec_illegal(dec_illegal)
    );

    // layout: [22:14] opcode [13] vex [12] r [11] x [10] b [9] w [8:5] vvvv
    //         [4] L [3] 66 [2] F3 [1] F2 [0] illegal
    function automatic logic [22:0] observed();
        return {dec_opcode, dec_vex, ext_r, ext_x, ext_b, op_wide, src_reg,
                vec_long, imp_opsize, imp_rep, imp_repne, dec_illegal};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model computed from the requirements.
    task automatic model(input logic [1:0] md, input logic v86, input logic [4:0] fl,
                         input logic [7:0] b0, b1, b2, b3);
        logic [8:0] opc;
        logic [7:0] last;
        logic       vx, r, x, b, w, ill;
        logic       lead;
        opc = '0; vx = 0; r = 0; x = 0; b = 0; w = 0; ill = 0; last = 8'h78;
        lead = (b0 == 8'hC4) || (b0 == 8'hC5);
        if (!lead || !((md == 2'd1 || md == 2'd2) && !v86)) begin
            opc = {1'b0, b0}; e_n = 1; e_tag = lead ? "R2" : "R1";
        end else if (md != 2'd2 && b1[7:6] != 2'b11) begin
            opc = {1'b0, b0}; e_n = 1; e_tag = "R3";
        end else if (fl != 0) begin
            ill = 1; e_n = 2; e_tag = "R4";
        end else if (b0 == 8'hC5) begin
            vx = 1; r = ~b1[7]; last = b1; opc = {1'b1, b2}; e_n = 3; e_tag = "R8";
        end else if (b1[4:0] < 5'd1 || b1[4:0] > 5'd3) begin
            ill = 1; e_n = 2; e_tag = "R6";
        end else begin
            vx = 1; r = ~b1[7]; x = ~b1[6]; b = ~b1[5]; w = b2[7]; last = b2; e_tag = "R6";
            if (b1[4:0] == 5'd1) begin opc = {1'b1, b3}; e_n = 4; end
            else if (b1[4:0] == 5'd2) begin opc = 9'h138; e_n = 3; end
            else begin opc = 9'h13A; e_n = 3; end
        end
        if (vx)
            e_vec = {opc, 1'b1, r, x, b, w, ~last[6:3], last[2],
                     last[1:0] == 2'd1, last[1:0] == 2'd2, last[1:0] == 2'd3, 1'b0};
        else
            e_vec = {opc, 13'd0, ill};
    endtask

    // Drive one instruction and compare the finished result with the model.
    task automatic run(input logic [1:0] md, input logic v86, input logic [4:0] fl,
                       input logic [7:0] b0, b1, b2, b3);
        logic [7:0]  q [4];
        logic [22:0] act;
        int          idx;
        logic        got;
        logic        acc;
        q = '{b0, b1, b2, b3};
        model(md, v86, fl, b0, b1, b2, b3);
        cpu_mode = md; v86_mode = v86;
        {seen_lock, seen_opsize, seen_rep, seen_repne, seen_rex} = fl;
        idx = 0; got = 0; act = '0;
        for (int c = 0; c < 16 && !got; c++) begin
            @(negedge clk);
            if (dec_done) begin
                got = 1;
                act = observed();
                byte_valid = 1'b0;
            end else begin
                byte_valid = (idx < 4);
                byte_data  = (idx < 4) ? q[idx] : 8'h00;
                #1;
                acc = byte_valid && byte_ready;
                @(posedge clk);
                if (acc) idx++;
            end
        end
        byte_valid = 1'b0;
        if (!got) begin
            check("R11 done missing", 32'd0, 32'd1);
        end else begin
            check({e_tag, " opcode/flags"}, {9'd0, act[22:13], 12'd0, act[0]},
                  {9'd0, e_vec[22:13], 12'd0, e_vec[0]});
            if (e_vec[13]) begin
                check("R5 extension bits", act[12:10], e_vec[12:10]);
                check("R7 width bit", act[9], e_vec[9]);
                check("R9 last-byte fields", act[8:1], e_vec[8:1]);
            end else begin
                check("R10 default fields", act[12:1], 12'd0);
            end
            check(e_tag == "R3" ? "R3 bytes consumed" : "R11 bytes consumed", idx, e_n);
            @(negedge clk);
            check("R11 pulse and hold", {dec_done, observed()}, {1'b0, act});
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R12 reset outputs", {dec_done, observed()}, 24'd0);

        // R1: every single byte in 32-bit mode
        for (int v = 0; v < 256; v++)
            if (v != 8'hC4 && v != 8'hC5)
                run(2'd1, 1'b0, 5'd0, v[7:0], 8'h00, 8'h00, 8'h00);

        // R3, R8, R9: two-byte form, every follow-on byte in 32-bit mode
        for (int v = 0; v < 256; v++)
            run(2'd1, 1'b0, 5'd0, 8'hC5, v[7:0], 8'h58, 8'h00);

        // R5, R6: three-byte form, every first payload byte in 64-bit mode
        for (int v = 0; v < 256; v++)
            run(2'd2, 1'b0, 5'd0, 8'hC4, v[7:0], 8'hA5, 8'h2F);

        // R7, R9: every second payload byte
        for (int v = 0; v < 256; v++)
            run(2'd2, 1'b0, 5'd0, 8'hC4, 8'h61, v[7:0], 8'h10);

        // R2: mode, virtual-8086 and lead-byte grid
        for (int m = 0; m < 3; m++)
            for (int vm = 0; vm < 2; vm++) begin
                run(m[1:0], vm[0], 5'd0, 8'hC4, 8'hE2, 8'h7D, 8'h00);
                run(m[1:0], vm[0], 5'd0, 8'hC5, 8'hF9, 8'h6F, 8'h00);
            end

        // R4: each stale legacy prefix flag, both forms
        for (int f = 0; f < 5; f++) begin
            run(2'd1, 1'b0, 5'(1 << f), 8'hC5, 8'hF8, 8'h77, 8'h00);
            run(2'd2, 1'b0, 5'(1 << f), 8'hC4, 8'hE3, 8'h79, 8'h0F);
        end

        // R12: reset taken mid-instruction
        @(negedge clk);
        cpu_mode = 2'd1; v86_mode = 1'b0;
        {seen_lock, seen_opsize, seen_rep, seen_repne, seen_rex} = 5'd0;
        byte_valid = 1'b1; byte_data = 8'hC4;
        @(negedge clk);
        byte_valid = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R12 reset mid-instruction", {dec_done, observed()}, 24'd0);
        run(2'd1, 1'b0, 5'd0, 8'h90, 8'h00, 8'h00, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule